// File: doc/BRIEF.md
# Return Stack with Carry Save

This block is the hardware return stack of a small 4-bit processor whose program counter is 12 bits wide. Whenever the core enters a subroutine or an interrupt handler, it pushes one entry that holds the return address together with the current carry flag. The address pushed is the caller's incremented program counter, meaning the instruction that follows the call, and the core works it out before the push. When the core returns, it pops the top entry. The stack hands back the stored address and carry bit, and it signals whether the core should reload the carry.

The stack holds four levels, and calls and interrupt entries share them. It is built as a shift register, so a push made while it is full pushes the deepest entry out and loses it. Nothing flags this.

There are two kinds of return:
- **Interrupt return:** the core reloads both the address and the carry.
- **Value return:** the core reloads only the address. It keeps its carry, and it takes its accumulator and table-branch values from elsewhere.

The stack marks which kind is being taken on one output line.

Top module: `retStack`

## Requirements
- R1: After reset, depth is 0, retPc is 0, retCarry is 0 and restoreCarry is 0.
- R2: A push stores {pushCarry, pushPc} as one 13-bit entry with the carry in bit 12. From the next cycle the entry appears on retCarry/retPc as the top.
- R3: Pops return entries in last-in first-out order. The top entry is shown on retPc/retCarry during the cycle in which popEn is high, and the next older entry is shown from the following cycle.
- R4: Each push raises depth by one. Depth saturates at 4.
- R5: A fifth push with no pop in between discards the oldest entry. After pushes A,B,C,D,E, four pops return E,D,C,B.
- R6: Each pop with depth above 0 lowers depth by one.
- R7: restoreCarry is 1 exactly in a cycle where a pop is taken with popRestoreCarry=1 (interrupt return). A pop with popRestoreCarry=0 (value return) keeps restoreCarry at 0, and retCarry still shows the stored bit.
- R8: A pop at depth 0 leaves depth at 0. It returns all zeros if nothing was pushed since reset; otherwise it returns the deepest entry the stack last held. The top output does not change.
- R9: If pushEn and popEn are both 1 in one cycle, the push is taken and the pop is ignored: depth rises, the new entry becomes the top, and restoreCarry stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Push strobe (call or interrupt entry) |
| pushPc | input | 12 | Return address to save |
| pushCarry | input | 1 | Carry flag to save |
| popEn | input | 1 | Pop strobe (return) |
| popRestoreCarry | input | 1 | 1: interrupt return (reload carry), 0: value return |
| retPc | output | 12 | Address in the top entry |
| retCarry | output | 1 | Carry bit in the top entry |
| restoreCarry | output | 1 | Core must reload carry this cycle |
| depth | output | 3 | Number of valid entries, 0 to 4 |

## Verification
The tests cover four patterns:
- **Short nested pair with mixed carries:** shows whether the order is last-in first-out and whether the carry travels with its own address.
- **Five-deep burst followed by draining pops:** separates a stack that drops its bottom entry from one that blocks the push or wraps around.
- **Pops past empty:** shows whether the returned value is zeros after reset, or the entry last held at the bottom after an overflow.
- **Push and pop in the same cycle:** shows that push priority is respected.

// File: rtl/retStackPkg.sv
package retStackPkg;
  typedef struct packed {
    logic shiftIn;   // move entries one level deeper, load new top
    logic shiftOut;  // move entries one level up, bottom holds
  } stackCtrlT;
endpackage

// File: rtl/retStackCtrl.sv
module retStackCtrl
  import retStackPkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushEn,
  input  logic               popEn,
  input  logic               popRestoreCarry,
  output stackCtrlT          ctrl,
  output logic               restoreCarry,
  output logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  logic doPush;
  logic doPop;

  assign doPush = pushEn;
  assign doPop  = popEn & ~pushEn;

  assign ctrl.shiftIn  = doPush;
  assign ctrl.shiftOut = doPop;
  assign restoreCarry  = doPop & popRestoreCarry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
    end else if (doPush) begin
      if (depth != FULL) depth <= depth + 1'b1;
    end else if (doPop) begin
      if (depth != '0) depth <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/retStackData.sv
module retStackData
  import retStackPkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  stackCtrlT       ctrl,
  input  logic [PC_W-1:0] pushPc,
  input  logic            pushCarry,
  output logic [PC_W-1:0] retPc,
  output logic            retCarry
);
  localparam int ENTRY_W = PC_W + 1;

  logic [ENTRY_W-1:0] stk [DEPTH];
  logic [ENTRY_W-1:0] newEntry;

  assign newEntry = {pushCarry, pushPc};

  for (genvar lvl = 0; lvl < DEPTH; lvl++) begin : g_level
    logic [ENTRY_W-1:0] fromAbove;
    logic [ENTRY_W-1:0] fromBelow;

    if (lvl == 0) begin : g_top
      assign fromAbove = newEntry;
    end else begin : g_mid
      assign fromAbove = stk[lvl-1];
    end

    if (lvl == DEPTH - 1) begin : g_bottom
      assign fromBelow = stk[lvl];
    end else begin : g_upper
      assign fromBelow = stk[lvl+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stk[lvl] <= '0;
      end else if (ctrl.shiftIn) begin
        stk[lvl] <= fromAbove;
      end else if (ctrl.shiftOut) begin
        stk[lvl] <= fromBelow;
      end
    end
  end

  assign retCarry = stk[0][ENTRY_W-1];
  assign retPc    = stk[0][PC_W-1:0];
endmodule

// File: rtl/retStack.sv
module retStack
  import retStackPkg::*;
#(
  parameter int PC_W    = 12,
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushEn,
  input  logic [PC_W-1:0]    pushPc,
  input  logic               pushCarry,
  input  logic               popEn,
  input  logic               popRestoreCarry,
  output logic [PC_W-1:0]    retPc,
  output logic               retCarry,
  output logic               restoreCarry,
  output logic [DEPTH_W-1:0] depth
);
  stackCtrlT ctrl;

  retStackCtrl #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .popRestoreCarry(popRestoreCarry), .ctrl(ctrl),
    .restoreCarry(restoreCarry), .depth(depth)
  );

  retStackData #(.PC_W(PC_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pushPc(pushPc),
    .pushCarry(pushCarry), .retPc(retPc), .retCarry(retCarry)
  );
endmodule

// File: rtl/retStackChecker.sv
module retStackChecker #(
  parameter int PC_W    = 12,
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               pushEn,
  input logic [PC_W-1:0]    pushPc,
  input logic               pushCarry,
  input logic               popEn,
  input logic               popRestoreCarry,
  input logic [PC_W-1:0]    retPc,
  input logic               retCarry,
  input logic               restoreCarry,
  input logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL) else $error("depth above limit"); // R4

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |=> (retPc == $past(pushPc)) && (retCarry == $past(pushCarry)))
    else $error("pushed entry not on top"); // R2

  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && depth != FULL) |=> depth == $past(depth) + 1'b1)
    else $error("push did not raise depth"); // R4

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && depth == FULL) |=> depth == FULL)
    else $error("depth left full on overflow push"); // R5

  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && depth != '0) |=> depth == $past(depth) - 1'b1)
    else $error("pop did not lower depth"); // R6

  AST_RESTORE_ONLY_IRET: assert property (@(posedge clk) disable iff (!rstN)
    restoreCarry |-> (popEn && popRestoreCarry && !pushEn))
    else $error("restoreCarry outside interrupt return"); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && depth == '0) |=> (depth == '0) && $stable(retPc) && $stable(retCarry))
    else $error("empty pop changed state"); // R8

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn) |-> !restoreCarry)
    else $error("pop taken during push"); // R9
endmodule

bind retStack retStackChecker #(.PC_W(PC_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushPc(pushPc), .pushCarry(pushCarry),
  .popEn(popEn), .popRestoreCarry(popRestoreCarry), .retPc(retPc), .retCarry(retCarry),
  .restoreCarry(restoreCarry), .depth(depth)
);

// File: tb/test_retStack.sv
`timescale 1ns/1ps
module test_retStack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushEn = 1'b0;
  logic [11:0] pushPc = '0;
  logic        pushCarry = 1'b0;
  logic        popEn = 1'b0;
  logic        popRestoreCarry = 1'b0;
  logic [11:0] retPc;
  logic        retCarry;
  logic        restoreCarry;
  logic [2:0]  depth;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  retStack i_retStack (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushPc(pushPc), .pushCarry(pushCarry),
    .popEn(popEn), .popRestoreCarry(popRestoreCarry), .retPc(retPc), .retCarry(retCarry),
    .restoreCarry(restoreCarry), .depth(depth)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; pushEn = 1'b0; popEn = 1'b0; popRestoreCarry = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic push(input logic [11:0] pc, input logic c);
    pushEn = 1'b1; pushPc = pc; pushCarry = c;
    @(negedge clk);
    pushEn = 1'b0;
  endtask

  // drives a pop at a falling edge, checks outputs during the pop cycle
  task automatic pop(input string req, input logic sel, input logic [11:0] expPc,
                     input logic expC, input logic expRestore);
    popEn = 1'b1; popRestoreCarry = sel;
    #1;
    check(req, "retPc during pop", int'(retPc), int'(expPc));
    check(req, "retCarry during pop", int'(retCarry), int'(expC));
    check("R7", "restoreCarry during pop", int'(restoreCarry), int'(expRestore));
    @(negedge clk);
    popEn = 1'b0; popRestoreCarry = 1'b0;
  endtask

  task automatic testReset();
    applyReset();
    check("R1", "depth", int'(depth), 0);
    check("R1", "retPc", int'(retPc), 0);
    check("R1", "retCarry", int'(retCarry), 0);
    check("R1", "restoreCarry", int'(restoreCarry), 0);
  endtask

  task automatic testNested();
    applyReset();
    push(12'h123, 1'b1);
    check("R2", "top pc", int'(retPc), 'h123);
    check("R2", "top carry", int'(retCarry), 1);
    push(12'h456, 1'b0);
    check("R4", "depth after 2 pushes", int'(depth), 2);
    pop("R3", 1'b1, 12'h456, 1'b0, 1'b1);
    check("R6", "depth after pop", int'(depth), 1);
    pop("R3", 1'b0, 12'h123, 1'b1, 1'b0);
    check("R6", "depth after 2 pops", int'(depth), 0);
  endtask

  task automatic testEmptyAfterReset();
    applyReset();
    pop("R8", 1'b1, 12'h000, 1'b0, 1'b1);
    check("R8", "depth stays 0", int'(depth), 0);
    check("R8", "retPc after empty pop", int'(retPc), 0);
  endtask

  task automatic testOverflow();
    applyReset();
    for (int k = 1; k <= 5; k++) begin
      push(12'hA00 + 12'(k), k[0]);
      if (k <= 4) check("R4", "depth while filling", int'(depth), k);
    end
    check("R4", "depth saturated", int'(depth), 4);
    for (int k = 5; k >= 2; k--) begin
      pop("R5", 1'b1, 12'hA00 + 12'(k), k[0], 1'b1);
    end
    check("R6", "depth drained", int'(depth), 0);
    pop("R8", 1'b0, 12'hA02, 1'b0, 1'b0);
    check("R8", "depth after empty pop", int'(depth), 0);
  endtask

  task automatic testCollision();
    applyReset();
    push(12'h321, 1'b0);
    pushEn = 1'b1; pushPc = 12'h777; pushCarry = 1'b1;
    popEn = 1'b1; popRestoreCarry = 1'b1;
    #1;
    check("R9", "restoreCarry on collision", int'(restoreCarry), 0);
    @(negedge clk);
    pushEn = 1'b0; popEn = 1'b0; popRestoreCarry = 1'b0;
    check("R9", "depth after collision", int'(depth), 2);
    check("R9", "top pc after collision", int'(retPc), 'h777);
    pop("R9", 1'b1, 12'h777, 1'b1, 1'b1);
    pop("R9", 1'b1, 12'h321, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    testReset();
    testNested();
    testEmptyAfterReset();
    testOverflow();
    testCollision();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule